// File: doc/BRIEF.md
# Per-ID Bandwidth Reservation Controller

This block keeps a table of reserved bandwidth blocks, one entry per resource control ID, behind a small 64-bit register port. Software writes a reservation into a staging register and then issues a command to the allocation-control register. A commit command copies the staged count into the entry for one ID. A fetch command copies that entry back into the staging register. A busy flag stays high for a fixed number of cycles while a command runs. When busy drops, a status code tells software how the command ended.

The controller keeps a running sum of all entries. It refuses any commit that would push this sum above the reservable ceiling published in its capabilities register. Only the low 16-bit count field of the staging register is ever changed by the hardware. Software may use the upper bits freely, and a fetch leaves them as they were.

Top module: `bw_resv_ctrl`

## Requirements
- R1: The register at byte offset 0 reads {16'b0, max reservable blocks[47:32], 8'b0, total bandwidth blocks[23:8], major version[7:4], minor version[3:0]}, with defaults 200, 256, 1 and 0. Writes to it have no effect.
- R2: The registers at offsets 8 and 16 always read zero, and writes to them have no effect. Any other offset also reads zero.
- R3: The staging register at offset 32 stores all 64 written bits. A successful fetch replaces only bits [15:0].
- R4: The control register at offset 24 reads back the command in [4:0] and the ID in [19:8], status in [38:32] and busy in bit 39. Bits [7:5] always read 0. Accepting a command sets busy and clears status to 0 for exactly BUSY_CYC (default 4) cycles.
- R5: A write to the control register while busy is set is ignored: command, ID, busy timing and status are unchanged.
- R6: Command 1 with a valid ID, within the ceiling, stores the staged count (staging bits [15:0] at the cycle of acceptance) in that ID's entry and ends with status 1.
- R7: Command 2 with a valid ID loads the entry into staging bits [15:0] and ends with status 1. Commit, clear of the count field, then fetch returns the committed count exactly.
- R8: A commit whose new total over all entries (the old entry for that ID replaced) exceeds the ceiling ends with status 4 and leaves the table unchanged. A total equal to the ceiling is accepted.
- R9: A command code other than 1 or 2 ends with status 2 and changes neither the table nor the staging register.
- R10: An ID not below NUM_IDS (default 16) ends with status 3 and changes neither the table nor the staging register.
- R11: After reset the control register, the staging register and every table entry are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 64 | Write data |
| rd_addr | input | 6 | Byte offset of the read |
| rd_data | output | 64 | Read data, combinational from rd_addr |

## Verification
A wrong table entry or running total stays hidden until a later fetch returns it to staging bits [15:0], or until a later commit for some other ID is accepted or refused against the ceiling in the wrong way. A fault in busy timing shows on bit 39 of the control register in the very cycle it occurs, so the readback is compared on every clock against a behavioural model. Because the command and ID fields are latched, a command accepted while busy is visible at once in the control register.

// File: rtl/bw_resv_pkg.sv
`timescale 1ns/1ps
// Shared constants for the bandwidth reservation controller.
// Assumes 64-bit registers decoded on 8-byte aligned byte offsets.
package bw_resv_pkg;
    localparam int OFF_CAPS  = 0;
    localparam int OFF_MONC  = 8;
    localparam int OFF_MONV  = 16;
    localparam int OFF_CTRL  = 24;
    localparam int OFF_STAGE = 32;

    localparam logic [4:0] CMD_COMMIT = 5'd1;
    localparam logic [4:0] CMD_FETCH  = 5'd2;

    typedef enum logic [6:0] {
        ST_NONE  = 7'd0,
        ST_OK    = 7'd1,
        ST_BADOP = 7'd2,
        ST_BADID = 7'd3,
        ST_OVER  = 7'd4
    } status_t;
endpackage

// File: rtl/bw_resv_seq.sv
`timescale 1ns/1ps
// Command sequencer: latches an accepted command, its ID and the staged
// count, holds busy for BUSY_CYC cycles, then pulses done and records
// the result status. Assumes issue is only raised while busy is low.
module bw_resv_seq
    import bw_resv_pkg::*;
#(
    parameter int BUSY_CYC = 4,
    parameter int ID_W     = 12,
    parameter int BLK_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [4:0]       cmd_in,
    input  logic [ID_W-1:0]  id_in,
    input  logic [BLK_W-1:0] val_in,
    input  status_t          result,
    output logic             busy,
    output logic             done,
    output logic [4:0]       cmd_q,
    output logic [ID_W-1:0]  id_q,
    output logic [BLK_W-1:0] val_q,
    output status_t          status_q
);
    localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // The command finishes in the last busy cycle.
    assign done = busy && (cnt == '0);

    // Latch the command on acceptance; count down; retire with status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cmd_q    <= '0;
            id_q     <= '0;
            val_q    <= '0;
            status_q <= ST_NONE;
        end else if (issue) begin
            busy     <= 1'b1;
            cnt      <= CNT_LOAD;
            cmd_q    <= cmd_in;
            id_q     <= id_in;
            val_q    <= val_in;
            status_q <= ST_NONE;
        end else if (done) begin
            busy     <= 1'b0;
            status_q <= result;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/bw_resv_table.sv
`timescale 1ns/1ps
// Per-ID reservation table with a running total. Judges the pending
// command (bad code, bad ID, over ceiling) and applies a commit on done.
// Assumes NUM_IDS >= 2 and NUM_IDS <= 2**ID_W.
module bw_resv_table
    import bw_resv_pkg::*;
#(
    parameter int NUM_IDS = 16,
    parameter int ID_W    = 12,
    parameter int BLK_W   = 16,
    parameter int MRBWB   = 200,
    parameter int TOT_W   = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [4:0]       cmd,
    input  logic [ID_W-1:0]  id,
    input  logic [BLK_W-1:0] val,
    output status_t          result,
    output logic [BLK_W-1:0] rd_val,
    output logic [TOT_W-1:0] total
);
    localparam int IDX_W = $clog2(NUM_IDS);
    localparam logic [ID_W:0]    ID_LIM = (ID_W+1)'(NUM_IDS);
    localparam logic [TOT_W-1:0] CEIL   = TOT_W'(MRBWB);

    logic [BLK_W-1:0] entry [NUM_IDS];
    logic             id_ok;
    logic [IDX_W-1:0] idx;
    logic [TOT_W-1:0] new_total;

    assign id_ok     = {1'b0, id} < ID_LIM;
    assign idx       = id[IDX_W-1:0];
    assign rd_val    = id_ok ? entry[idx] : '0;
    assign new_total = total - TOT_W'(rd_val) + TOT_W'(val);

    // Decide the outcome of the pending command, checks in priority order.
    always_comb begin
        result = ST_OK;
        if (cmd != CMD_COMMIT && cmd != CMD_FETCH) begin
            result = ST_BADOP;
        end else if (!id_ok) begin
            result = ST_BADID;
        end else if (cmd == CMD_COMMIT && new_total > CEIL) begin
            result = ST_OVER;
        end
    end

    // Store an accepted commit and keep the running total in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDS; i++) entry[i] <= '0;
            total <= '0;
        end else if (done && cmd == CMD_COMMIT && result == ST_OK) begin
            entry[idx] <= val;
            total      <= new_total;
        end
    end
endmodule

// File: rtl/bw_resv_ctrl.sv
`timescale 1ns/1ps
// Top of the bandwidth reservation controller: register decode, staging
// register and readback mux around the sequencer and the table.
// Assumes one write per cycle and aligned 8-byte offsets; reads are
// combinational and have no side effects.
module bw_resv_ctrl
    import bw_resv_pkg::*;
#(
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 0,
    parameter int NBWBLKS   = 256,
    parameter int MRBWB     = 200,
    parameter int NUM_IDS   = 16,
    parameter int BUSY_CYC  = 4,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data
);
    localparam int ID_W  = 12;
    localparam int BLK_W = 16;
    localparam int TOT_W = BLK_W + $clog2(NUM_IDS) + 1;
    localparam logic [63:0] CAPS_VAL = {16'b0, 16'(MRBWB), 8'b0, 16'(NBWBLKS),
                                        4'(VER_MAJOR), 4'(VER_MINOR)};

    logic             busy, done, issue, wr_stage;
    logic [4:0]       cmd_q;
    logic [ID_W-1:0]  id_q;
    logic [BLK_W-1:0] val_q, rd_val;
    logic [TOT_W-1:0] total;
    status_t          status_q, result;
    logic [63:0]      stage;

    assign issue    = wr_en && (wr_addr == ADDR_W'(OFF_CTRL)) && !busy;
    assign wr_stage = wr_en && (wr_addr == ADDR_W'(OFF_STAGE));

    bw_resv_seq #(.BUSY_CYC(BUSY_CYC), .ID_W(ID_W), .BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .cmd_in(wr_data[4:0]), .id_in(wr_data[19:8]), .val_in(stage[BLK_W-1:0]),
        .result(result), .busy(busy), .done(done),
        .cmd_q(cmd_q), .id_q(id_q), .val_q(val_q), .status_q(status_q)
    );

    bw_resv_table #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .BLK_W(BLK_W),
                    .MRBWB(MRBWB), .TOT_W(TOT_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .done(done), .cmd(cmd_q), .id(id_q),
        .val(val_q), .result(result), .rd_val(rd_val), .total(total)
    );

    // Staging register: software writes all bits, a fetch fills the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            if (wr_stage) stage <= wr_data;
            if (done && cmd_q == CMD_FETCH && result == ST_OK)
                stage[BLK_W-1:0] <= rd_val;
        end
    end

    // Readback mux; monitor offsets and holes read as zero.
    always_comb begin
        case (rd_addr)
            ADDR_W'(OFF_CAPS):  rd_data = CAPS_VAL;
            ADDR_W'(OFF_CTRL):  rd_data = {24'b0, busy, status_q, 12'b0, id_q, 3'b000, cmd_q};
            ADDR_W'(OFF_STAGE): rd_data = stage;
            default:            rd_data = '0;
        endcase
    end
endmodule

// File: rtl/bw_resv_chk.sv
`timescale 1ns/1ps
// Property checker for bw_resv_ctrl, attached by bind below. Watches
// busy timing, latched command fields and the running reservation total.
module bw_resv_chk
    import bw_resv_pkg::*;
#(
    parameter int BUSY_CYC = 4,
    parameter int MRBWB    = 200,
    parameter int TOT_W    = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [4:0]       cmd_q,
    input logic [11:0]      id_q,
    input status_t          status_q,
    input logic [TOT_W-1:0] total
);
    int busy_len;

    // Count cycles already spent busy for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= 0;
        else                 busy_len <= busy_len + 1;
    end

    p_busy_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_len < BUSY_CYC);
    p_busy_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(busy_len) == BUSY_CYC - 1);
    p_status_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status_q == ST_NONE);
    p_hold_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$rose(busy)) |-> ($stable(cmd_q) && $stable(id_q)));
    p_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (status_q != ST_NONE));
    p_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        total <= TOT_W'(MRBWB));
    p_total_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(total));
endmodule

bind bw_resv_ctrl bw_resv_chk #(.BUSY_CYC(BUSY_CYC), .MRBWB(MRBWB), .TOT_W(TOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_q(cmd_q), .id_q(id_q),
    .status_q(status_q), .total(total)
);

// File: tb/sim_bw_resv_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural model updated every clock and compared on every
// clock, plus directed checks tagged by requirement.
module sim_bw_resv_ctrl;
    localparam int BUSY  = 4;
    localparam int NIDS  = 16;
    localparam int CEIL  = 200;
    localparam logic [63:0] CAPS = (64'd200 << 32) | (64'd256 << 8) | (64'd1 << 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    bw_resv_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                     .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

    always #2.5 clk = ~clk;

    // Behavioural model state.
    int          m_tbl [NIDS];
    logic [63:0] m_stage;
    int m_cmd, m_id, m_busy, m_left, m_st, m_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NIDS; i++) m_tbl[i] = 0;
            m_stage = 0; m_cmd = 0; m_id = 0; m_busy = 0; m_left = 0; m_st = 0; m_val = 0;
        end else begin
            int old_busy, old_lo, st, sum;
            old_busy = m_busy;
            old_lo   = int'(m_stage[15:0]);
            if (wr_en && wr_addr == 6'd32) m_stage = wr_data;
            if (old_busy != 0) begin
                if (m_left == 0) begin
                    m_busy = 0;
                    if (m_cmd != 1 && m_cmd != 2) st = 2;
                    else if (m_id >= NIDS) st = 3;
                    else if (m_cmd == 1) begin
                        sum = 0;
                        for (int i = 0; i < NIDS; i++) sum += (i == m_id) ? m_val : m_tbl[i];
                        if (sum > CEIL) st = 4;
                        else begin st = 1; m_tbl[m_id] = m_val; end
                    end else begin
                        st = 1;
                        m_stage[15:0] = 16'(m_tbl[m_id]);
                    end
                    m_st = st;
                end else m_left--;
            end
            if (wr_en && wr_addr == 6'd24 && old_busy == 0) begin
                m_cmd = int'(wr_data[4:0]); m_id = int'(wr_data[19:8]);
                m_busy = 1; m_left = BUSY - 1; m_st = 0; m_val = old_lo;
            end
        end
    end

    function automatic logic [63:0] model_rd(logic [5:0] a);
        case (a)
            6'd0:  return CAPS;
            6'd24: return (64'(m_busy) << 39) | (64'(m_st) << 32) | (64'(m_id) << 8) | 64'(m_cmd);
            6'd32: return m_stage;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare the visible register with the model every cycle.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            case (rd_addr)
                6'd0:    check("R1", rd_data, model_rd(rd_addr));
                6'd24:   check("R4", rd_data, model_rd(rd_addr));
                6'd32:   check("R3", rd_data, model_rd(rd_addr));
                default: check("R2", rd_data, model_rd(rd_addr));
            endcase
        end
    end

    task automatic wr(logic [5:0] a, logic [63:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(string req, logic [5:0] a, logic [63:0] exp);
        rd_addr = a; #0.5;
        check(req, rd_data, exp);
    endtask

    // Issue a command and wait until busy has dropped.
    task automatic cmd(int c, int id);
        wr(6'd24, (64'(id) << 8) | 64'(c));
        repeat (BUSY) @(negedge clk);
    endtask

    function automatic logic [63:0] ctl(int c, int id, int st);
        return (64'(st) << 32) | (64'(id) << 8) | 64'(c);
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        peek("R11", 6'd24, 64'd0);
        peek("R11", 6'd32, 64'd0);
        peek("R1", 6'd0, CAPS);
        // R1 / R2 writes ignored
        wr(6'd0, '1);  peek("R1", 6'd0, CAPS);
        wr(6'd8, '1);  peek("R2", 6'd8, 64'd0);
        wr(6'd16, '1); peek("R2", 6'd16, 64'd0);
        peek("R2", 6'd40, 64'd0);
        // R3 staging holds every bit
        wr(6'd32, 64'hABCD_0000_0000_0032);
        peek("R3", 6'd32, 64'hABCD_0000_0000_0032);
        // R4 busy during command, R5 write while busy ignored
        wr(6'd24, ctl(1, 3, 0));
        peek("R4", 6'd24, (64'd1 << 39) | ctl(1, 3, 0));
        wr(6'd24, ctl(2, 5, 0));
        peek("R5", 6'd24, (64'd1 << 39) | ctl(1, 3, 0));
        repeat (BUSY - 1) @(negedge clk);
        peek("R6", 6'd24, ctl(1, 3, 1));
        // R7 clear count, fetch restores it, upper bits kept
        wr(6'd32, 64'hABCD_0000_0000_0000);
        cmd(2, 3);
        peek("R7", 6'd32, 64'hABCD_0000_0000_0032);
        // R8 ceiling: 50 + 150 = 200 accepted, +1 refused
        wr(6'd32, 64'd150); cmd(1, 5); peek("R8", 6'd24, ctl(1, 5, 1));
        wr(6'd32, 64'd1);   cmd(1, 7); peek("R8", 6'd24, ctl(1, 7, 4));
        cmd(2, 7); peek("R8", 6'd32, 64'd0);
        wr(6'd32, 64'd51);  cmd(1, 3); peek("R8", 6'd24, ctl(1, 3, 4));
        wr(6'd32, 64'd40);  cmd(1, 3); peek("R8", 6'd24, ctl(1, 3, 1));
        // R9 unknown command: no side effects
        wr(6'd32, 64'h1234_0000_0000_0077);
        cmd(7, 5); peek("R9", 6'd24, ctl(7, 5, 2));
        peek("R9", 6'd32, 64'h1234_0000_0000_0077);
        cmd(0, 5); peek("R9", 6'd24, ctl(0, 5, 2));
        cmd(2, 5); peek("R9", 6'd32, 64'h1234_0000_0000_0096);
        // R10 out-of-range ID: no side effects
        wr(6'd32, 64'd9);
        cmd(1, 16);   peek("R10", 6'd24, ctl(1, 16, 3));
        cmd(2, 4095); peek("R10", 6'd24, ctl(2, 4095, 3));
        peek("R10", 6'd32, 64'd9);
        cmd(2, 0);    peek("R10", 6'd32, 64'd0);
        // R4 access-type bits read zero
        wr(6'd24, ctl(2, 3, 0) | 64'h0E0);
        repeat (BUSY) @(negedge clk);
        peek("R4", 6'd24, ctl(2, 3, 1));
        peek("R7", 6'd32, 64'd40);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule